// File: doc/BRIEF.md
# MDIO Clause-22 Management Master

This block lets software reach the management registers of Ethernet PHYs over a two-wire management bus. A small register file on a simple 32-bit write/read bus holds a divider code, a command word, a target address, outgoing write data, the last read result and a status word. Software first sets the PHY and register numbers. A write frame starts when the data register is written. A read frame starts when a command bit is written, and software clears that bit again afterwards.

Each frame has 64 bit-times, sent most significant bit first: 32 preamble ones, start `01`, opcode (`10` read, `01` write), 5-bit PHY address, 5-bit register address, a 2-bit turnaround (`10` driven on writes, released on reads), then 16 data bits. The management clock idles low. Its half-period is set by the divider code, so one setting can suit several system clock rates. Outgoing bits change only when the clock falls. Incoming bits are sampled when it rises. A reset bit in the configuration word stops a frame in progress at once.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, `mdc` is low, `mdio_oe` is low, the status word (0x14) and the read-result word (0x10) read 0, the address word (0x08) reads 0 and the configuration word (0x00) reads the default divider code 7.
- R2: The address word at 0x08 stores the PHY number in bits 12:8 and the register number in bits 4:0. Every other bit reads 0.
- R3: Writing the data word at 0x0C while idle starts a write frame to the stored address. The frame is 32 ones, `01`, opcode `01`, PHY, register, `10`, then bits 15:0 of the written value, MSB first.
- R4: Writing the command word at 0x04 with bit 0 set while idle starts a read frame with opcode `10`. `mdio_oe` is low from the first turnaround bit to the end of the frame. The 16 bits sampled on the data rising edges appear in bits 15:0 of 0x10 once busy clears.
- R5: Bit 0 of the status word at 0x14 (busy) reads 1 from the cycle after an accepted start until the frame ends.
- R6: While a frame is driven, `mdio_o` changes only in the cycle where `mdc` falls.
- R7: The `mdc` half-period is (code + 1) system clock cycles, where code is bits 3:0 of the configuration word.
- R8: A start request (a data-word write, or a command write with bit 0 set) that arrives while busy is ignored, including one sampled on the very edge that ends a frame. The data and command words keep their previous values.
- R9: Writing the configuration word with bit 31 set stops any frame at once: busy reads 0, `mdc` is low and `mdio_oe` is low. Bits 3:0 of the same write become the new code, and bit 31 reads back 0.
- R10: Bit 2 of the status word flags an invalid read. It is set when a read frame ends and the PHY did not pull the line low in the second turnaround bit. It is cleared when the next read starts.
- R11: The command word stores every value accepted into it, so software can read back the bit it must clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte address of the register (reads and writes) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Drive enable for `mdio_o` |
| mdio_i | input | 1 | Management data in (line value) |

## Verification
Two things can coincide in one cycle: a new start request and the clock edge that ends the current frame, where busy is still high at the sampling edge. The bench first issues a write frame. It then counts exactly 128 × (code + 1) cycles and places a second data-word write on the very edge where the frame ends. It judges the outcome at the pins through a bus-functional PHY that counts the frames it decodes and keeps their contents: exactly one frame must appear, carrying the first value, and the data word must still hold that value. A later write, made once the block is idle, must then be accepted.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int FRAME_BITS = 64;
  localparam int DATA_BITS  = 16;

  localparam int OFF_CFG   = 'h00;
  localparam int OFF_CMD   = 'h04;
  localparam int OFF_ADDR  = 'h08;
  localparam int OFF_WDATA = 'h0C;
  localparam int OFF_RDATA = 'h10;
  localparam int OFF_STAT  = 'h14;

  // mdc half-period in system clock cycles for a divider code
  function automatic logic [15:0] mdc_half_cycles(input logic [15:0] code);
    return code + 16'd1;
  endfunction

  // Whole serial frame, bit 63 goes on the wire first
  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic       rd,
    input logic [4:0] phy,
    input logic [4:0] rg,
    input logic [15:0] data
  );
    logic [1:0] op;
    logic [1:0] ta;
    logic [15:0] pay;
    op  = rd ? 2'b10 : 2'b01;
    ta  = rd ? 2'b11 : 2'b10;
    pay = rd ? 16'hFFFF : data;
    return {32'hFFFF_FFFF, 2'b01, op, phy, rg, ta, pay};
  endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] code,
  output logic             half_tick
);
  import mdio_mgmt_pkg::*;

  logic [DIV_W:0] cnt_q;
  logic [15:0]    half_len;

  assign half_len  = mdc_half_cycles(16'(code));
  assign half_tick = run && (16'(cnt_q) == half_len - 16'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!run)      cnt_q <= '0;
    else if (half_tick) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  // R7: a half-period longer than one cycle never ticks twice in a row
  assert_tick_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (half_tick && code != '0) |=> (!half_tick || code == '0));

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine #(
  parameter int FRAME_BITS = 64,
  parameter int DATA_W     = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  abort,
  input  logic                  is_read,
  input  logic [FRAME_BITS-1:0] frame,
  input  logic                  half_tick,
  input  logic                  mdio_i,
  output logic                  busy,
  output logic                  mdc,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic                  done,
  output logic                  rd_done,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  rd_bad
);
  localparam int IDX_W    = $clog2(FRAME_BITS);
  localparam int TA_IDX   = FRAME_BITS - DATA_W - 2;
  localparam int DATA_IDX = FRAME_BITS - DATA_W;
  localparam int LAST_IDX = FRAME_BITS - 1;

  logic [FRAME_BITS-1:0] sr_q;
  logic [IDX_W-1:0]      idx_q, idx_nxt;
  logic                  rd_q, busy_q, mdc_q, out_q, oe_q, bad_q;
  logic [DATA_W-1:0]     cap_q;
  logic                  at_last, rise_ev, fall_ev;

  assign idx_nxt = idx_q + 1'b1;
  assign at_last = (idx_q == IDX_W'(LAST_IDX));
  assign rise_ev = busy_q && half_tick && !mdc_q;
  assign fall_ev = busy_q && half_tick && mdc_q;
  assign done    = fall_ev && at_last;
  assign rd_done = done && rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0; idx_q <= '0; rd_q <= 1'b0; busy_q <= 1'b0;
      mdc_q <= 1'b0; out_q <= 1'b0; oe_q <= 1'b0; bad_q <= 1'b0; cap_q <= '0;
    end else if (abort) begin
      busy_q <= 1'b0; mdc_q <= 1'b0; out_q <= 1'b0; oe_q <= 1'b0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        sr_q   <= frame;
        rd_q   <= is_read;
        idx_q  <= '0;
        mdc_q  <= 1'b0;
        out_q  <= frame[FRAME_BITS-1];
        oe_q   <= 1'b1;
        bad_q  <= 1'b0;
      end
    end else if (rise_ev) begin
      mdc_q <= 1'b1;
      if (rd_q && idx_q == IDX_W'(TA_IDX + 1)) bad_q <= mdio_i;
      if (rd_q && idx_q >= IDX_W'(DATA_IDX))   cap_q <= {cap_q[DATA_W-2:0], mdio_i};
    end else if (fall_ev) begin
      mdc_q <= 1'b0;
      if (at_last) begin
        busy_q <= 1'b0;
        out_q  <= 1'b0;
        oe_q   <= 1'b0;
      end else begin
        idx_q <= idx_nxt;
        sr_q  <= {sr_q[FRAME_BITS-2:0], 1'b0};
        out_q <= sr_q[FRAME_BITS-2];
        oe_q  <= !(rd_q && idx_nxt >= IDX_W'(TA_IDX));
      end
    end
  end

  assign busy    = busy_q;
  assign mdc     = mdc_q;
  assign mdio_o  = out_q;
  assign mdio_oe = oe_q;
  assign rd_data = cap_q;
  assign rd_bad  = bad_q;

  // R1: the bus clock and drive are quiet whenever no frame runs
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!mdc_q && !oe_q));

  // R6: driven data moves only with a falling mdc
  assert_fall_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && oe_q && $past(oe_q) && !$stable(out_q)) |-> $fell(mdc_q));

  // R4: line released from turnaround to the end of a read
  assert_read_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rd_q && idx_q >= IDX_W'(TA_IDX)) |-> !oe_q);

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
  parameter int ADDR_W  = 6,
  parameter int DIV_W   = 4,
  parameter int DEF_DIV = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  import mdio_mgmt_pkg::*;

  logic [DIV_W-1:0]     div_q;
  logic [31:0]          cmd_q;
  logic [4:0]           phy_q, reg_q;
  logic [15:0]          wdata_q, rdata_q;
  logic                 invalid_q;

  logic                 sel_cfg, sel_cmd, sel_addr, sel_wdata;
  logic                 wr_req, rd_req, start_req, start_go, soft_rst;
  logic                 eng_busy, eng_done, eng_rd_done, eng_bad, half_tick;
  logic [15:0]          eng_rd_data;
  logic [FRAME_BITS-1:0] frame;

  assign sel_cfg   = bus_wr && bus_addr == ADDR_W'(OFF_CFG);
  assign sel_cmd   = bus_wr && bus_addr == ADDR_W'(OFF_CMD);
  assign sel_addr  = bus_wr && bus_addr == ADDR_W'(OFF_ADDR);
  assign sel_wdata = bus_wr && bus_addr == ADDR_W'(OFF_WDATA);

  assign wr_req    = sel_wdata;
  assign rd_req    = sel_cmd && bus_wdata[0];
  assign start_req = wr_req || rd_req;
  assign soft_rst  = sel_cfg && bus_wdata[31];
  assign start_go  = start_req && !eng_busy;
  assign frame     = build_frame(rd_req, phy_q, reg_q, bus_wdata[15:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_W'(DEF_DIV); cmd_q <= '0; phy_q <= '0; reg_q <= '0;
      wdata_q <= '0; rdata_q <= '0; invalid_q <= 1'b0;
    end else begin
      if (sel_cfg) div_q <= bus_wdata[DIV_W-1:0];
      if (sel_addr) begin
        phy_q <= bus_wdata[12:8];
        reg_q <= bus_wdata[4:0];
      end
      if (sel_cmd && !eng_busy)   cmd_q   <= bus_wdata;
      if (sel_wdata && !eng_busy) wdata_q <= bus_wdata[15:0];
      if (start_go && rd_req) invalid_q <= 1'b0;
      if (eng_rd_done) begin
        rdata_q   <= eng_rd_data;
        invalid_q <= eng_bad;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFF_CFG):   bus_rdata = 32'(div_q);
      ADDR_W'(OFF_CMD):   bus_rdata = cmd_q;
      ADDR_W'(OFF_ADDR):  bus_rdata = {19'b0, phy_q, 3'b0, reg_q};
      ADDR_W'(OFF_WDATA): bus_rdata = {16'b0, wdata_q};
      ADDR_W'(OFF_RDATA): bus_rdata = {16'b0, rdata_q};
      ADDR_W'(OFF_STAT):  bus_rdata = {29'b0, invalid_q, 1'b0, eng_busy};
      default:            bus_rdata = '0;
    endcase
  end

  mdio_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(eng_busy), .code(div_q), .half_tick(half_tick)
  );

  mdio_frame_engine #(.FRAME_BITS(FRAME_BITS), .DATA_W(DATA_BITS)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start_go), .abort(soft_rst), .is_read(rd_req),
    .frame(frame), .half_tick(half_tick), .mdio_i(mdio_i), .busy(eng_busy),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(eng_done),
    .rd_done(eng_rd_done), .rd_data(eng_rd_data), .rd_bad(eng_bad)
  );

  // R5: an accepted start makes the engine busy on the next edge
  assert_busy_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !eng_busy && !soft_rst) |=> eng_busy);

  // R8: requests arriving while busy leave the stored words alone
  assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && eng_busy) |=> ($stable(wdata_q) && $stable(cmd_q)));

  // R9: soft reset ends the frame on the next edge
  assert_soft_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!eng_busy && !mdc));

  // R5: busy only ever ends through a frame end or a soft reset
  assert_busy_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eng_busy) |-> ($past(eng_done) || $past(soft_rst)));

endmodule

// File: tb/mdio_mgmt_master_test.sv
`timescale 1ns/1ps
module mdio_mgmt_master_test;

  typedef struct packed {
    logic        rd;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] d;
    logic [3:0]  code;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{rd:1'b0, phy:5'h01, rg:5'h00, d:16'h9000, code:4'h1},
    '{rd:1'b1, phy:5'h04, rg:5'h11, d:16'h0000, code:4'h4},
    '{rd:1'b0, phy:5'h1F, rg:5'h1F, d:16'hA5C3, code:4'h0},
    '{rd:1'b1, phy:5'h10, rg:5'h02, d:16'h0000, code:4'h9},
    '{rd:1'b0, phy:5'h00, rg:5'h10, d:16'h0001, code:4'h7},
    '{rd:1'b1, phy:5'h1F, rg:5'h00, d:16'h0000, code:4'h5}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic mdc, mdio_o, mdio_oe, mdio_i;

  always #2 clk = ~clk;

  mdio_mgmt_master uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int compared = 0;
  int mismatched = 0;

  // bus-functional PHY
  logic phy_present = 1'b1;
  logic phy_drv = 1'b0;
  logic phy_val = 1'b1;
  logic mdio_line;
  assign mdio_line = mdio_oe ? mdio_o : (phy_drv ? phy_val : 1'b1);
  assign mdio_i = mdio_line;

  function automatic logic [15:0] phy_model(input logic [4:0] p, input logic [4:0] r);
    return {r, p, 6'h25};
  endfunction

  bit hunting = 1'b1;
  int ones = 0;
  int k = 0;
  logic [1:0] cur_op;
  logic [4:0] cur_phy, cur_reg;
  logic [15:0] cur_dat;
  logic [1:0] cur_ta;
  int frames = 0;
  logic [1:0] last_op;
  logic [4:0] last_phy, last_reg;
  logic [15:0] last_dat;
  logic [1:0] last_ta;

  always @(posedge mdc) begin
    if (hunting) begin
      if (mdio_line) ones = ones + 1;
      else begin
        if (ones >= 32) begin hunting = 1'b0; k = 32; end
        ones = 0;
      end
    end else begin
      k = k + 1;
      if (k == 34 || k == 35) cur_op  = {cur_op[0], mdio_line};
      if (k >= 36 && k <= 40) cur_phy = {cur_phy[3:0], mdio_line};
      if (k >= 41 && k <= 45) cur_reg = {cur_reg[3:0], mdio_line};
      if (k == 46 || k == 47) cur_ta  = {cur_ta[0], mdio_line};
      if (k >= 48)            cur_dat = {cur_dat[14:0], mdio_line};
      if (k == 63) begin
        frames = frames + 1;
        last_op = cur_op; last_phy = cur_phy; last_reg = cur_reg;
        last_dat = cur_dat; last_ta = cur_ta;
        hunting = 1'b1; ones = 0;
      end
    end
  end

  always @(negedge mdc) begin
    logic [15:0] mv;
    int nk;
    nk = k + 1;
    mv = phy_model(cur_phy, cur_reg);
    if (!hunting && phy_present && cur_op == 2'b10 && nk >= 47 && nk <= 63) begin
      phy_drv <= 1'b1;
      phy_val <= (nk == 47) ? 1'b0 : mv[15 - (nk - 48)];
    end else begin
      phy_drv <= 1'b0;
      phy_val <= 1'b1;
    end
  end

  // R6 monitor: driven data must only move when mdc falls
  int edge_viol = 0;
  logic p_mdc = 1'b0, p_oe = 1'b0, p_o = 1'b0;
  always @(negedge clk) begin
    if (rst_n && p_oe && mdio_oe && (mdio_o != p_o) && !(p_mdc && !mdc))
      edge_viol = edge_viol + 1;
    p_mdc = mdc; p_oe = mdio_oe; p_o = mdio_o;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared = compared + 1;
    if (!ok) begin
      mismatched = mismatched + 1;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] s;
    bit ok;
    ok = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      bus_read(6'h14, s);
      if (!s[0]) begin ok = 1'b1; break; end
    end
    check(ok, req, {31'b0, ok}, 32'h1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    mismatched = mismatched + 1;
    compared = compared + 1;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int f0;
    realtime t0, t1;
    int h;

    repeat (5) @(negedge clk);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins in reset", {30'b0, mdc, mdio_oe}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_read(6'h14, r); check(r == 32'h0, "R1 status", r, 32'h0);
    bus_read(6'h10, r); check(r == 32'h0, "R1 read result", r, 32'h0);
    bus_read(6'h08, r); check(r == 32'h0, "R1 address", r, 32'h0);
    bus_read(6'h00, r); check(r == 32'h7, "R1 divider default", r, 32'h7);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins idle", {30'b0, mdc, mdio_oe}, 32'h0);

    // R2 address layout
    bus_write(6'h08, 32'hFFFF_FFFF);
    bus_read(6'h08, r); check(r == 32'h0000_1F1F, "R2 address mask", r, 32'h1F1F);

    // R11 command readback
    bus_write(6'h04, 32'h0000_0000);
    bus_read(6'h04, r); check(r == 32'h0, "R11 command cleared", r, 32'h0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      vec_t tv;
      tv = VECS[v];
      h = int'(tv.code) + 1;
      f0 = frames;
      bus_write(6'h00, {28'b0, tv.code});
      bus_write(6'h08, {19'b0, tv.phy, 3'b0, tv.rg});
      if (tv.rd) begin
        bus_write(6'h04, 32'h0);
        bus_write(6'h04, 32'h1);
      end else begin
        bus_write(6'h0C, {16'b0, tv.d});
      end
      bus_read(6'h14, r); check(r[0] == 1'b1, "R5 busy after start", r, 32'h1);
      @(posedge mdc); t0 = $realtime;
      @(posedge mdc); t1 = $realtime;
      check(int'((t1 - t0) / 4.0) == 2 * h, "R7 mdc period",
            32'(int'((t1 - t0) / 4.0)), 32'(2 * h));
      wait_idle("R5 busy clears");
      check(frames == f0 + 1, "R3 one frame seen", 32'(frames - f0), 32'h1);
      check(last_phy == tv.phy && last_reg == tv.rg, "R3 frame address",
            {22'b0, last_phy, last_reg}, {22'b0, tv.phy, tv.rg});
      if (tv.rd) begin
        check(last_op == 2'b10, "R4 read opcode", {30'b0, last_op}, 32'h2);
        bus_read(6'h04, r); check(r == 32'h1, "R11 command readback", r, 32'h1);
        bus_write(6'h04, 32'h0);
        bus_read(6'h10, r);
        check(r == {16'b0, phy_model(tv.phy, tv.rg)}, "R4 read result", r, {16'b0, phy_model(tv.phy, tv.rg)});
        bus_read(6'h14, r); check(r[2] == 1'b0, "R10 valid read", r, 32'h0);
      end else begin
        check(last_op == 2'b01 && last_ta == 2'b10, "R3 write opcode and turnaround",
              {28'b0, last_op, last_ta}, 32'h6);
        check(last_dat == tv.d, "R3 write data", {16'b0, last_dat}, {16'b0, tv.d});
      end
    end

    // R8: requests while busy ignored
    bus_write(6'h00, 32'h1);
    bus_write(6'h08, 32'h0000_0203);
    f0 = frames;
    bus_write(6'h0C, 32'h0000_1234);
    bus_write(6'h0C, 32'h0000_BEEF);
    bus_write(6'h04, 32'h0000_0001);
    bus_read(6'h0C, r); check(r == 32'h1234, "R8 data word kept", r, 32'h1234);
    bus_read(6'h04, r); check(r == 32'h0, "R8 command word kept", r, 32'h0);
    wait_idle("R8 busy clears");
    repeat (400) @(negedge clk);
    check(frames == f0 + 1, "R8 single frame", 32'(frames - f0), 32'h1);
    check(last_dat == 16'h1234 && last_op == 2'b01, "R8 first request wins",
          {14'b0, last_op, last_dat}, 32'h0001_1234);

    // R8: request on the frame-ending edge (code 1, h = 2)
    f0 = frames;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 6'h0C; bus_wdata = 32'h0000_5A5A;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    repeat (128 * 2 - 1) @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 6'h0C; bus_wdata = 32'h0000_C0DE;
    @(negedge clk);
    bus_wr = 1'b0;
    bus_read(6'h14, r); check(r[0] == 1'b0, "R8 idle after coincident edge", r, 32'h0);
    repeat (400) @(negedge clk);
    check(frames == f0 + 1, "R8 coincident request dropped", 32'(frames - f0), 32'h1);
    check(last_dat == 16'h5A5A, "R8 coincident frame data", {16'b0, last_dat}, 32'h5A5A);
    bus_read(6'h0C, r); check(r == 32'h5A5A, "R8 coincident data word", r, 32'h5A5A);
    bus_write(6'h0C, 32'h0000_0F0F);
    wait_idle("R3 later write");
    check(frames == f0 + 2 && last_dat == 16'h0F0F, "R3 later write accepted",
          {16'b0, last_dat}, 32'h0F0F);

    // R10: no PHY answer
    phy_present = 1'b0;
    bus_write(6'h08, 32'h0000_0505);
    bus_write(6'h04, 32'h1);
    wait_idle("R10 busy clears");
    bus_write(6'h04, 32'h0);
    bus_read(6'h14, r); check(r[2] == 1'b1, "R10 invalid set", r, 32'h4);
    phy_present = 1'b1;
    bus_write(6'h04, 32'h1);
    bus_read(6'h14, r); check(r[2] == 1'b0 && r[0] == 1'b1, "R10 cleared at start", r, 32'h1);
    wait_idle("R10 busy clears again");
    bus_write(6'h04, 32'h0);
    bus_read(6'h10, r);
    check(r == {16'b0, phy_model(5'h05, 5'h05)}, "R4 read after recovery", r, {16'b0, phy_model(5'h05, 5'h05)});

    check(edge_viol == 0, "R6 data moved off falling edge", 32'(edge_viol), 32'h0);

    // R9: soft reset mid-frame
    bus_write(6'h00, 32'h9);
    bus_write(6'h0C, 32'h0000_7777);
    repeat (200) @(negedge clk);
    bus_write(6'h00, 32'h8000_0003);
    bus_read(6'h14, r); check(r[0] == 1'b0, "R9 busy cleared", r, 32'h0);
    bus_read(6'h00, r); check(r == 32'h3, "R9 code kept, reset bit reads 0", r, 32'h3);
    begin
      bit quiet;
      quiet = 1'b1;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (mdc || mdio_oe) quiet = 1'b0;
      end
      check(quiet, "R9 mdc low after abort", {31'b0, quiet}, 32'h1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule